// File: doc/BRIEF.md
# Channel-Status Block Serializer

This block sits beside a digital-audio transmit framer. It holds a page of six 32-bit channel-status words, 192 bits in all, which covers one 192-frame audio block. On every frame start it gives the framer the one channel-status bit that belongs to that frame. The framer encodes that bit into its outgoing subframe. The biphase encoding and all receive-side work are done elsewhere.

The page arrives as a single flat input vector. A word is copied into an internal shifter when its turn comes. The surrounding logic can therefore rewrite the page at any time, and a change to the word now being sent does not corrupt that word. A busy flag tells the rest of the transmit path when the block's leading words are being sent. It rises when the first word is loaded. It falls when the last word is loaded, or at the first frame boundary after transmission is switched off.

Top module: `cs_block_serializer`

## Requirements
- R1: Page word k (k = 0..5, word 0 is the first word sent) occupies page_i bits [32k+31 : 32k].
- R2: When frame_i, tx_en_i, cs_en_i and block_i are all high in the same cycle, word 0 is loaded. From the next cycle cs_bit_o shows bit 0 of that word.
- R3: Each later frame_i pulse with tx_en_i and cs_en_i high and block_i low moves the output to the next bit. Bits within a word go out from the least significant bit upward.
- R4: After bit 31 of a word has been sent, the next frame_i pulse loads the following word. The order is 0,1,2,3,4,5 and then back to 0, even when no block_i pulse arrives.
- R5: busy_o goes high in the cycle after word 0 is loaded, whether the load comes from block_i or from the wrap.
- R6: busy_o goes low in the cycle after word 5 is loaded.
- R7: A frame_i pulse while tx_en_i is low clears busy_o in the next cycle and stops the serializer. cs_bit_o then stays 0 until a later block_i pulse restarts it.
- R8: While cs_en_i is low, cs_bit_o is 0 and frame_i pulses do not move the bit position. When cs_en_i returns, output resumes from the same bit.
- R9: A change to a page word that is already in the shifter does not alter the bits sent from that copy. The new value is used at that word's next load.
- R10: After reset, busy_o and cs_bit_o are 0.
- R11: A block_i pulse that comes with a frame_i pulse in the middle of a block restarts output at word 0, bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| page_i | input | 192 | Six channel-status words, word k in bits [32k+31:32k] |
| tx_en_i | input | 1 | Transmitter enabled |
| cs_en_i | input | 1 | Channel-status insertion enabled |
| frame_i | input | 1 | One-cycle strobe at each frame start |
| block_i | input | 1 | Marks the frame that starts a block; sampled only together with frame_i |
| cs_bit_o | output | 1 | Channel-status bit for the current frame |
| busy_o | output | 1 | Block words 0 to 4 are being sent |

## Verification
The hardest cases to reach are the ones where several controls meet at a word boundary. Examples are a page rewrite that lands while its word sits in the shifter, a channel-status pause in the middle of a word, and a wrap from the last word back to the first with no block pulse present. The stimulus runs a full block, then starts a second block in which it rewrites the whole page in the middle of word 2. It then drops cs_en_i for several frames, forces a realignment in the middle of the block, and switches transmission off. Finally it runs more than 192 frames with no block pulse. A behavioural model that keeps only a bit position and a copy of the loaded word is compared with both outputs on every cycle.

// File: rtl/cs_ser_pkg.sv
package cs_ser_pkg;
  // index of the word that follows cur in an n-word page
  function automatic int next_word_idx(int cur, int n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

  // true when bit index b is the last bit of a word of width w
  function automatic bit is_last_bit(int b, int w);
    return b == w - 1;
  endfunction
endpackage

// File: rtl/cs_word_select.sv
module cs_word_select #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 6,
  localparam int IDX_W  = $clog2(N_WORDS)
) (
  input  logic [N_WORDS*WORD_W-1:0] page_i,
  input  logic [IDX_W-1:0]          sel_i,
  output logic [WORD_W-1:0]         word_o
);
  logic [WORD_W-1:0] words [N_WORDS];

  for (genvar g = 0; g < N_WORDS; g++) begin : g_slice
    assign words[g] = page_i[g*WORD_W +: WORD_W];
  end

  always_comb begin
    word_o = '0;
    for (int k = 0; k < N_WORDS; k++) begin
      if (sel_i == IDX_W'(k)) word_o = words[k];
    end
  end
endmodule

// File: rtl/cs_position.sv
module cs_position #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 6,
  localparam int IDX_W  = $clog2(N_WORDS),
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             step_i,
  output logic [BIT_W-1:0] bit_idx_o,
  output logic [IDX_W-1:0] word_idx_o,
  output logic [IDX_W-1:0] next_idx_o,
  output logic             wrap_o
);
  import cs_ser_pkg::*;

  assign next_idx_o = IDX_W'(next_word_idx(int'(word_idx_o), N_WORDS));
  assign wrap_o     = step_i && is_last_bit(int'(bit_idx_o), WORD_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx_o  <= '0;
      word_idx_o <= '0;
    end else if (restart_i) begin
      bit_idx_o  <= '0;
      word_idx_o <= '0;
    end else if (wrap_o) begin
      bit_idx_o  <= '0;
      word_idx_o <= next_idx_o;
    end else if (step_i) begin
      bit_idx_o  <= bit_idx_o + 1'b1;
    end
  end

  AST_WORD_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(word_idx_o) < N_WORDS); // R4
  AST_WRAP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && !restart_i) |=> (bit_idx_o == '0) && (word_idx_o != $past(word_idx_o))); // R4
endmodule

// File: rtl/cs_block_serializer.sv
module cs_block_serializer #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 6,
  localparam int IDX_W  = $clog2(N_WORDS),
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int PAGE_W = WORD_W * N_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              tx_en_i,
  input  logic              cs_en_i,
  input  logic              frame_i,
  input  logic              block_i,
  output logic              cs_bit_o,
  output logic              busy_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  // named events
  logic              frame_go, restart_evt, step_evt, stop_evt, load_evt;
  logic              wrap_evt, load_first, load_last;
  logic [IDX_W-1:0]  word_idx, next_idx, load_idx;
  logic [BIT_W-1:0]  bit_idx;
  logic [WORD_W-1:0] sel_word, shift_q;
  logic              run_q;

  assign frame_go    = frame_i && tx_en_i && cs_en_i;
  assign restart_evt = frame_go && block_i;
  assign step_evt    = frame_go && !block_i && run_q;
  assign stop_evt    = frame_i && !tx_en_i;
  assign load_evt    = restart_evt || wrap_evt;
  assign load_idx    = restart_evt ? '0 : next_idx;
  assign load_first  = load_evt && (load_idx == '0);
  assign load_last   = load_evt && (load_idx == LAST_IDX);

  cs_position #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) pos_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (restart_evt),
    .step_i     (step_evt),
    .bit_idx_o  (bit_idx),
    .word_idx_o (word_idx),
    .next_idx_o (next_idx),
    .wrap_o     (wrap_evt)
  );

  cs_word_select #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) sel_i (
    .page_i (page_i),
    .sel_i  (load_idx),
    .word_o (sel_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      run_q   <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      if (load_evt)      shift_q <= sel_word;
      else if (step_evt) shift_q <= shift_q >> 1;

      if (stop_evt)         run_q <= 1'b0;
      else if (restart_evt) run_q <= 1'b1;

      if (stop_evt)        busy_o <= 1'b0;
      else if (load_first) busy_o <= 1'b1;
      else if (load_last)  busy_o <= 1'b0;
    end
  end

  assign cs_bit_o = run_q && cs_en_i && shift_q[0];

  AST_BUSY_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> busy_o); // R5
  AST_BUSY_OFF_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (load_last && !stop_evt) |=> !busy_o); // R6
  AST_TX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!busy_o && !cs_bit_o)); // R7
  AST_CS_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_en_i |=> ($stable(bit_idx) && $stable(word_idx))); // R8
  AST_CS_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_en_i && !run_q) |-> !cs_bit_o); // R8
  AST_RESTART_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> (bit_idx == '0 && word_idx == '0)); // R11
endmodule

// File: tb/cs_block_serializer_tb.sv
`timescale 1ns/100ps
module cs_block_serializer_tb_top;
  localparam int NW = 6;
  localparam int WW = 32;
  localparam int NB = NW * WW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] page = '0;
  logic          tx_en = 1'b0, cs_en = 1'b0, frame = 1'b0, blk = 1'b0;
  logic          cs_bit, busy;

  always #2.5 clk = ~clk;

  cs_block_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .page_i(page), .tx_en_i(tx_en),
    .cs_en_i(cs_en), .frame_i(frame), .block_i(blk),
    .cs_bit_o(cs_bit), .busy_o(busy)
  );

  // reference model: bit position in block, copy of loaded word
  int          m_pos = 0;
  bit          m_run = 0, m_busy = 0;
  logic [31:0] m_cur = '0;
  int          n_chk = 0, n_fail = 0, cycles = 0;
  bit          started = 0;
  string       cur_req = "R10";

  always @(posedge clk) begin
    cycles++;
    started = 1;
    if (!rst_n) begin
      m_pos = 0; m_run = 0; m_busy = 0; m_cur = '0;
    end else if (frame) begin
      if (!tx_en) begin
        m_run = 0; m_busy = 0;
      end else if (cs_en) begin
        if (blk) begin
          m_pos = 0; m_run = 1; m_cur = page[31:0]; m_busy = 1;
        end else if (m_run) begin
          m_pos = (m_pos + 1) % NB;
          if (m_pos % WW == 0) begin
            m_cur = page[m_pos +: 32];
            if (m_pos == 0)       m_busy = 1;
            if (m_pos == NB - WW) m_busy = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      logic eb;
      eb = (m_run && cs_en) ? m_cur[m_pos % WW] : 1'b0;
      n_chk += 2;
      if (cs_bit !== eb) begin
        n_fail++;
        $display("FAIL %s cs_bit pos=%0d actual=%b expected=%b", cur_req, m_pos, cs_bit, eb);
      end
      if (busy !== m_busy) begin
        n_fail++;
        $display("FAIL %s busy pos=%0d actual=%b expected=%b", cur_req, m_pos, busy, m_busy);
      end
    end
    if (cycles > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic step_in();
    @(negedge clk); #1;
  endtask

  task automatic send_frame(bit b);
    step_in(); frame = 1'b1; blk = b;
    step_in(); frame = 1'b0; blk = 1'b0;
    step_in(); step_in();
  endtask

  task automatic frames(int n);
    for (int i = 0; i < n; i++) send_frame(1'b0);
  endtask

  function automatic logic [NB-1:0] make_page(logic [31:0] seed);
    logic [NB-1:0] p;
    for (int k = 0; k < NW; k++)
      p[k*WW +: WW] = (seed * (k + 3)) ^ {k[7:0], 8'h5A, ~k[7:0], 8'hC3};
    return p;
  endfunction

  initial begin
    cur_req = "R10";
    repeat (4) step_in();
    rst_n = 1'b1;
    repeat (3) step_in();
    page = make_page(32'h9E37_79B9);
    tx_en = 1'b1; cs_en = 1'b1;
    frames(2);                       // R2: no block pulse yet, nothing sent
    cur_req = "R2"; send_frame(1'b1);
    cur_req = "R3"; frames(31);
    cur_req = "R4"; frames(128);
    cur_req = "R6"; frames(32);
    cur_req = "R5"; send_frame(1'b1);
    cur_req = "R4"; frames(69);
    cur_req = "R9"; page = make_page(32'h1234_ABCD); frames(30);
    cur_req = "R8"; cs_en = 1'b0; frames(5); send_frame(1'b1); cs_en = 1'b1; frames(10);
    cur_req = "R11"; send_frame(1'b1); frames(40);
    cur_req = "R7"; tx_en = 1'b0; frames(3); send_frame(1'b1); tx_en = 1'b1; frames(3);
    cur_req = "R1"; page = make_page(32'hC0FF_EE11); send_frame(1'b1);
    frames(191);
    cur_req = "R5"; frames(40);      // wrap back to word 0 with no block pulse
    cur_req = "R10"; rst_n = 1'b0; step_in(); step_in(); rst_n = 1'b1; frames(3);
    step_in();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule